// File: doc/BRIEF.md
# Binary Set-Combine and Output Select Stage

This block is the last stage of a binary compute unit in a pixel-stream image pipeline. Each cycle it receives, for every lane, the unit's untouched input pixel, two results from the bit-level logic elements, a reduction result and a median-filter result. Two operand multiplexers choose operands A and B for a 1-bit set engine, which forms union, intersection, complement, difference, exclusive-or (1-bit addition) or a straight copy of A. An output multiplexer then chooses what leaves the unit. It can pick the set result, or it can bypass the engine and pass on the raw pixel or any intermediate result.

All codes come from configuration inputs. They are captured only on a start-of-frame pulse, so a frame never mixes two settings. The result is registered together with its valid strobe. Stages can then be chained into deep pipelines or placed side by side on separate image slices. The `LANES` parameter sets how many pixels go through in parallel under one shared configuration.

Top module: `bset_out_stage`

## Requirements
- R1: While `rst` is high, at the next clock edge `out_valid` is 0 and `out_pix` is all zeros. The active configuration after reset is all codes 000: operation union, both operands logic result 0, output = original pixel.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock.
- R3: When `in_valid` is low in a cycle, `out_pix` is all zeros in the following cycle.
- R4: Operand select codes apply to A and B independently: 000 = logic result 0, 001 = logic result 1, 010 = reduction result, 011 = median result.
- R5: Set operation codes: 000 A|B, 001 A&B, 010 ~A, 011 A&~B, 100 A^B, 101 A.
- R6: Output select codes: 000 = original pixel, 001 = logic result 0, 010 = logic result 1, 011 = reduction, 100 = median, 101 = set-engine result. The value selected for a valid input appears on `out_pix` one clock later.
- R7: Unused codes drive 0. These are operand select codes 100 to 111 (the operand is 0), operation codes 110 and 111 (the set result is 0) and output select codes 110 and 111 (`out_pix` is 0).
- R8: Configuration inputs take effect only in a cycle where `sof` is high. That cycle's pixel already uses the new codes, and they stay active until the next `sof`. Configuration changes without `sof` have no effect on `out_pix`.
- R9: Every lane is computed from the same-index bits of the data inputs only, with the shared configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse; loads configuration |
| in_valid | input | 1 | Input lanes carry valid pixels |
| pix_orig | input | LANES | Unit's original input pixels |
| logic0 | input | LANES | Logic element 0 results |
| logic1 | input | LANES | Logic element 1 results |
| red_res | input | LANES | Reduction results |
| med_res | input | LANES | Median-filter results |
| cfg_op | input | 3 | Set operation code |
| cfg_sel_a | input | 3 | Operand A select code |
| cfg_sel_b | input | 3 | Operand B select code |
| cfg_out_sel | input | 3 | Output select code |
| out_pix | output | LANES | Registered output pixels |
| out_valid | output | 1 | Registered valid strobe |

## Verification
The assertions check on every cycle the one-clock valid alignment, the zeroed output after an idle cycle, and the reset values. They also check two output-select cases loaded by a start-of-frame pulse: the raw-pixel bypass and the unused codes that force zero. Only the bench scenarios can show the full operand, operation and output code tables, with every code combination swept. The bench scenarios also show that configuration held between frames ignores changes on the inputs, and that lanes stay independent under random data.

// File: rtl/bset_pkg.sv
package bset_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    OP_UNION  = 3'b000,
    OP_INTER  = 3'b001,
    OP_COMPL  = 3'b010,
    OP_DIFF   = 3'b011,
    OP_XOR    = 3'b100,
    OP_PASS_A = 3'b101
  } set_op_e;

  typedef enum logic [CODE_W-1:0] {
    SRC_LOGIC0 = 3'b000,
    SRC_LOGIC1 = 3'b001,
    SRC_RED    = 3'b010,
    SRC_MED    = 3'b011
  } opnd_sel_e;

  typedef enum logic [CODE_W-1:0] {
    OUT_ORIG   = 3'b000,
    OUT_LOGIC0 = 3'b001,
    OUT_LOGIC1 = 3'b010,
    OUT_RED    = 3'b011,
    OUT_MED    = 3'b100,
    OUT_SET    = 3'b101
  } out_sel_e;

  typedef struct packed {
    logic [CODE_W-1:0] op;
    logic [CODE_W-1:0] sel_a;
    logic [CODE_W-1:0] sel_b;
    logic [CODE_W-1:0] out_sel;
  } stage_cfg_t;

  localparam stage_cfg_t CFG_RESET = '0;
endpackage

// File: rtl/bset_cfg_hold.sv
module bset_cfg_hold
  import bset_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sof,
  input  stage_cfg_t cfg_in,
  output stage_cfg_t cfg_active
);
  stage_cfg_t shadow_q;

  // Frame-bound capture: new codes load only on the start-of-frame pulse.
  always_ff @(posedge clk) begin
    if (rst)      shadow_q <= CFG_RESET;
    else if (sof) shadow_q <= cfg_in;
  end

  // The start-of-frame pixel already sees the incoming codes.
  assign cfg_active = sof ? cfg_in : shadow_q;
endmodule

// File: rtl/bset_opnd_mux.sv
module bset_opnd_mux
  import bset_pkg::*;
(
  input  logic [CODE_W-1:0] sel,
  input  logic              logic0,
  input  logic              logic1,
  input  logic              red,
  input  logic              med,
  output logic              opnd
);
  always_comb begin
    case (sel)
      SRC_LOGIC0: opnd = logic0;
      SRC_LOGIC1: opnd = logic1;
      SRC_RED:    opnd = red;
      SRC_MED:    opnd = med;
      default:    opnd = 1'b0;
    endcase
  end
endmodule

// File: rtl/bset_set_engine.sv
module bset_set_engine
  import bset_pkg::*;
(
  input  logic [CODE_W-1:0] op,
  input  logic              a,
  input  logic              b,
  output logic              y
);
  always_comb begin
    case (op)
      OP_UNION:  y = a | b;
      OP_INTER:  y = a & b;
      OP_COMPL:  y = ~a;
      OP_DIFF:   y = a & ~b;
      OP_XOR:    y = a ^ b;
      OP_PASS_A: y = a;
      default:   y = 1'b0;
    endcase
  end
endmodule

// File: rtl/bset_lane.sv
module bset_lane
  import bset_pkg::*;
(
  input  stage_cfg_t cfg,
  input  logic       orig,
  input  logic       logic0,
  input  logic       logic1,
  input  logic       red,
  input  logic       med,
  output logic       res
);
  logic opnd_a, opnd_b, set_y;

  bset_opnd_mux i_mux_a (
    .sel(cfg.sel_a), .logic0(logic0), .logic1(logic1),
    .red(red), .med(med), .opnd(opnd_a)
  );

  bset_opnd_mux i_mux_b (
    .sel(cfg.sel_b), .logic0(logic0), .logic1(logic1),
    .red(red), .med(med), .opnd(opnd_b)
  );

  bset_set_engine i_engine (
    .op(cfg.op), .a(opnd_a), .b(opnd_b), .y(set_y)
  );

  always_comb begin
    case (cfg.out_sel)
      OUT_ORIG:   res = orig;
      OUT_LOGIC0: res = logic0;
      OUT_LOGIC1: res = logic1;
      OUT_RED:    res = red;
      OUT_MED:    res = med;
      OUT_SET:    res = set_y;
      default:    res = 1'b0;
    endcase
  end
endmodule

// File: rtl/bset_out_stage.sv
module bset_out_stage
  import bset_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              in_valid,
  input  logic [LANES-1:0]  pix_orig,
  input  logic [LANES-1:0]  logic0,
  input  logic [LANES-1:0]  logic1,
  input  logic [LANES-1:0]  red_res,
  input  logic [LANES-1:0]  med_res,
  input  logic [2:0]        cfg_op,
  input  logic [2:0]        cfg_sel_a,
  input  logic [2:0]        cfg_sel_b,
  input  logic [2:0]        cfg_out_sel,
  output logic [LANES-1:0]  out_pix,
  output logic              out_valid
);
  stage_cfg_t       cfg_in, cfg_act;
  logic [LANES-1:0] lane_res;

  assign cfg_in = '{op: cfg_op, sel_a: cfg_sel_a, sel_b: cfg_sel_b, out_sel: cfg_out_sel};

  bset_cfg_hold i_cfg (
    .clk(clk), .rst(rst), .sof(sof), .cfg_in(cfg_in), .cfg_active(cfg_act)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bset_lane i_lane (
      .cfg(cfg_act), .orig(pix_orig[g]), .logic0(logic0[g]), .logic1(logic1[g]),
      .red(red_res[g]), .med(med_res[g]), .res(lane_res[g])
    );
  end

  // Registered output: one clock of latency, idle cycles emit zeros.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      out_pix   <= in_valid ? lane_res : '0;
    end
  end
endmodule

// File: rtl/bset_out_stage_chk.sv
module bset_out_stage_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sof,
  input logic             in_valid,
  input logic [LANES-1:0] pix_orig,
  input logic [2:0]       cfg_out_sel,
  input logic [LANES-1:0] out_pix,
  input logic             out_valid
);
  // R1: reset clears the registered outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_pix == '0));

  // R2: valid follows the input strobe by one clock
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3: idle cycle gives zero output
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> out_pix == '0);

  // R6: bypass of original pixel loaded on a frame start
  a_r6_orig_bypass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sof && cfg_out_sel == 3'b000) |=> out_pix == $past(pix_orig));

  // R7: unused output select codes force zero
  a_r7_unused_out: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sof && cfg_out_sel[2:1] == 2'b11) |=> out_pix == '0);
endmodule

bind bset_out_stage bset_out_stage_chk #(.LANES(LANES)) i_chk (
  .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .pix_orig(pix_orig),
  .cfg_out_sel(cfg_out_sel), .out_pix(out_pix), .out_valid(out_valid)
);

// File: tb/test_bset_out_stage.sv
module test_bset_out_stage;
  localparam int LANES = 4;

  logic             clk = 1'b0;
  logic             rst, sof, in_valid;
  logic [LANES-1:0] pix_orig, logic0, logic1, red_res, med_res;
  logic [2:0]       cfg_op, cfg_sel_a, cfg_sel_b, cfg_out_sel;
  logic [LANES-1:0] out_pix;
  logic             out_valid;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench copy of the frame-held configuration: {op, sel_a, sel_b, out_sel}
  logic [11:0] m_cfg = '0;

  always #2 clk = ~clk;

  bset_out_stage #(.LANES(LANES)) i_bset_out_stage (
    .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .pix_orig(pix_orig),
    .logic0(logic0), .logic1(logic1), .red_res(red_res), .med_res(med_res),
    .cfg_op(cfg_op), .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b),
    .cfg_out_sel(cfg_out_sel), .out_pix(out_pix), .out_valid(out_valid)
  );

  function automatic logic [LANES-1:0] pick(input logic [2:0] s,
      input logic [LANES-1:0] l0, l1, r, m);
    if (s == 3'd0) return l0;
    if (s == 3'd1) return l1;
    if (s == 3'd2) return r;
    if (s == 3'd3) return m;
    return '0;
  endfunction

  function automatic logic [LANES-1:0] setop(input logic [2:0] op,
      input logic [LANES-1:0] a, b);
    logic [LANES-1:0] y;
    for (int i = 0; i < LANES; i++) begin
      case (op)
        3'd0: y[i] = a[i] | b[i];
        3'd1: y[i] = a[i] & b[i];
        3'd2: y[i] = !a[i];
        3'd3: y[i] = a[i] & !b[i];
        3'd4: y[i] = (a[i] + b[i]) % 2;
        3'd5: y[i] = a[i];
        default: y[i] = 1'b0;
      endcase
    end
    return y;
  endfunction

  task automatic check(input string tag, input logic [LANES-1:0] got, exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  // Drive one vector at a falling edge, then check after the next rising edge.
  task automatic step(input string tag, input bit v, input bit s,
      input logic [2:0] op, sa, sb, os);
    logic [11:0] eff;
    logic [LANES-1:0] a, b, res, e_pix;
    in_valid = v; sof = s;
    cfg_op = op; cfg_sel_a = sa; cfg_sel_b = sb; cfg_out_sel = os;
    pix_orig = LANES'($urandom); logic0 = LANES'($urandom);
    logic1 = LANES'($urandom); red_res = LANES'($urandom); med_res = LANES'($urandom);
    eff = s ? {op, sa, sb, os} : m_cfg;
    if (s) m_cfg = {op, sa, sb, os};
    a = pick(eff[8:6], logic0, logic1, red_res, med_res);
    b = pick(eff[5:3], logic0, logic1, red_res, med_res);
    case (eff[2:0])
      3'd0: res = pix_orig;
      3'd1: res = logic0;
      3'd2: res = logic1;
      3'd3: res = red_res;
      3'd4: res = med_res;
      3'd5: res = setop(eff[11:9], a, b);
      default: res = '0;
    endcase
    e_pix = v ? res : '0;
    @(negedge clk);
    check("R2 valid", LANES'(out_valid), LANES'(v));
    check(v ? tag : "R3 idle", out_pix, e_pix);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1; sof = 0; in_valid = 0;
    {pix_orig, logic0, logic1, red_res, med_res} = '0;
    {cfg_op, cfg_sel_a, cfg_sel_b, cfg_out_sel} = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", LANES'(out_valid), '0);
    check("R1 reset pix", out_pix, '0);
    rst = 0;
    // R1: reset configuration active without sof (codes given are ignored)
    for (int k = 0; k < 4; k++) step("R1 reset config", 1, 0, 3'd2, 3'd3, 3'd2, 3'd5);
    // R4 R5 R7: every op, operand A and operand B code through the set engine
    for (int op = 0; op < 8; op++)
      for (int sa = 0; sa < 8; sa++)
        for (int sb = 0; sb < 8; sb++)
          step("R4 R5 R7 set path", 1, 1, 3'(op), 3'(sa), 3'(sb), 3'd5);
    // R6 R7: every output select code
    for (int os = 0; os < 8; os++)
      for (int k = 0; k < 6; k++)
        step("R6 R7 out select", 1, 1, 3'd4, 3'd1, 3'd2, 3'(os));
    // R8: load a frame setting, then wiggle config without sof
    step("R8 load", 1, 1, 3'd3, 3'd2, 3'd3, 3'd5);
    for (int k = 0; k < 20; k++)
      step("R8 held config", 1, 0, 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
    step("R8 reload", 1, 1, 3'd0, 3'd0, 3'd1, 3'd2);
    for (int k = 0; k < 10; k++)
      step("R8 held config", 1, 0, 3'd7, 3'd7, 3'd7, 3'd7);
    // R9 R2 R3: random mix of valid, frame starts and codes
    for (int k = 0; k < 3000; k++)
      step("R9 random lanes", ($urandom % 4) != 0, ($urandom % 8) == 0,
           3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
    // R1: reset mid-stream clears outputs and configuration
    rst = 1; in_valid = 1;
    @(negedge clk);
    check("R1 reset pix", out_pix, '0);
    check("R1 reset valid", LANES'(out_valid), '0);
    rst = 0; m_cfg = '0;
    for (int k = 0; k < 4; k++) step("R1 reset config", 1, 0, 3'd1, 3'd1, 3'd1, 3'd1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule